// File: doc/BRIEF.md
# Half-Width Float Immediate Loader

This block turns a load-immediate instruction word into a double-precision register write. The instruction carries a destination register and a short immediate spread over two separate fields. The immediate is read as a bfloat16 bit pattern. It is widened without loss to IEEE binary64, which covers zeros, normal numbers, subnormals, infinities and NaNs. The result goes out on a single register-file write port.

A vector mode repeats the same write across consecutive registers, one per clock. This lets a single issue clear or fill a run of registers. A busy flag covers the whole run, and issues that arrive during the run are dropped. Fetch, other instructions, rounding and exception reporting are handled elsewhere.

Top module: `bfl_loader`

## Requirements
- R1: The instruction word maps, from bit 31 down to bit 0, as follows: major opcode `insn_i[31:26]`, destination `insn_i[25:21]`, 14-bit immediate `insn_i[20:7]`, extended opcode `insn_i[6:1]` and a lone immediate bit `insn_i[0]`. The bfloat16 pattern is the 14-bit field, followed by the lone bit written twice into bits 1 and 0.
- R2: A write happens only when the major opcode equals `MAJOR_OP` (default 19) and the extended opcode equals `EXT_OP` (default 2). Any other word produces no write enable.
- R3: After reset, `wr_en_o` and `busy_o` are low. In scalar mode (`vec_mode_i` = 0), an accepted issue produces exactly one write, in the next cycle, to the register index given by the destination field.
- R4: For a normal bfloat16 value, the sign is kept and the exponent is rebiased by adding 896. The 7 fraction bits are placed at the top of the 52-bit fraction, with zeros below.
- R5: Positive and negative zero widen to binary64 zero with the same sign.
- R6: An all-ones exponent (infinity or NaN) becomes exponent 0x7FF. The 7 fraction bits are kept left-aligned, so the NaN payload and the quiet bit survive.
- R7: A subnormal bfloat16 value is normalised. If its highest set fraction bit is at position p, the output exponent is 890+p and the output fraction holds the bits below that one, left-aligned. No output with a zero exponent has a nonzero fraction.
- R8: Pattern 0x7F80 gives 0x7FF0000000000000 (+infinity). Pattern 0xFF80 gives 0xFFF0000000000000 (−infinity). Pattern 0x3FFF gives 0x3FFFE00000000000 (+1.9921875).
- R9: In vector mode with effective length L, there are L writes on consecutive cycles, starting the cycle after issue. They go to the destination index, then the index plus 1, and so on, wrapping modulo the register count. All L writes carry the same data.
- R10: `busy_o` is high exactly while more vector writes remain after the current one. Issues that arrive while `busy_o` is high are ignored.
- R11: In vector mode, a length of 0 produces no write. A length above the register count (32) is treated as 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction valid strobe |
| insn_i | input | 32 | Instruction word |
| vec_mode_i | input | 1 | 1 selects the repeated vector write |
| vlen_i | input | 6 | Vector length |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Register write index |
| wr_data_o | output | 64 | binary64 write data |
| busy_o | output | 1 | Further vector writes pending |

## Verification
The bench sweeps every encodable immediate in scalar mode and compares each result with a value computed in real arithmetic. A converter that forgets to normalise subnormals would leave a zero exponent with a nonzero fraction. A converter that drops the fraction on an all-ones exponent would turn NaNs into infinities. The vector runs cover the full 32-register clear, wrap-around past the last index, a length of zero and an oversized length. A sequencer with an off-by-one count would emit one write too many or too few. A sequencer that let an issue in while busy would restart the index or write again after the run ends.

// File: rtl/bfl_pkg.sv
// Shared widths and the instruction layout for the float immediate loader.
// Assumes a 32-bit instruction word, numbered from bit 31 down to bit 0.
package bfl_pkg;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int IMM_W    = 14;
    localparam int XO_W     = 6;
    localparam int BF_W     = 16;
    localparam int BF_EXP_W = 8;
    localparam int BF_MAN_W = 7;
    localparam int BF_BIAS  = 127;
    localparam int DP_W     = 64;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int DP_BIAS  = 1023;

    // Packed with the MSB first, so the field order follows the word from bit 31 downward.
    typedef struct packed {
        logic [OPC_W-1:0] major;
        logic [REG_W-1:0] frt;
        logic [IMM_W-1:0] imm;
        logic [XO_W-1:0]  xo;
        logic             lone;
    } insn_t;
endpackage

// File: rtl/bfl_decode.sv
// Splits the instruction word into its fields and checks the opcodes.
// Builds the bfloat16 pattern from the 14-bit field plus the lone bit,
// which is written into both low bits. Purely combinational.
module bfl_decode import bfl_pkg::*; #(
    parameter logic [OPC_W-1:0] MAJOR_OP = 6'd19,
    parameter logic [XO_W-1:0]  EXT_OP   = 6'd2
) (
    input  logic [31:0]      insn_i,
    output logic             match_o,
    output logic [REG_W-1:0] frt_o,
    output logic [BF_W-1:0]  bf_o
);
    insn_t w;

    // Field view of the raw word
    assign w       = insn_t'(insn_i);
    // Accept only the configured opcode pair
    assign match_o = (w.major == MAJOR_OP) && (w.xo == EXT_OP);
    assign frt_o   = w.frt;
    // Lone bit fills both low positions of the pattern
    assign bf_o    = {w.imm, w.lone, w.lone};
endmodule

// File: rtl/bfl_widen.sv
// Widens a bfloat16 pattern exactly to binary64. Subnormal inputs are
// normalised with a leading-one search. The exponent and fraction of
// NaNs and infinities are carried over as they are. Purely combinational.
module bfl_widen import bfl_pkg::*; (
    input  logic [BF_W-1:0] bf_i,
    output logic [DP_W-1:0] dp_o
);
    localparam int PW = $clog2(BF_MAN_W);
    localparam logic [DP_EXP_W-1:0] NORM_OFS = DP_EXP_W'(DP_BIAS - BF_BIAS);
    localparam logic [DP_EXP_W-1:0] SUB_BASE = DP_EXP_W'(DP_BIAS - (BF_BIAS - 1) - BF_MAN_W);

    logic                sgn;
    logic [BF_EXP_W-1:0] exp_in;
    logic [BF_MAN_W-1:0] man_in;
    logic [PW-1:0]       lead_pos;
    logic [PW:0]         shamt;
    logic [BF_MAN_W-1:0] sub_frac;
    logic [DP_EXP_W-1:0] exp_out;
    logic [BF_MAN_W-1:0] frac_out;

    assign {sgn, exp_in, man_in} = bf_i;

    // Position of the highest set fraction bit
    always_comb begin
        lead_pos = '0;
        for (int i = 0; i < BF_MAN_W; i++) begin
            if (man_in[i]) lead_pos = PW'(i);
        end
    end

    // Shift the leading one out of the top to get the normalised fraction
    assign shamt    = (PW+1)'(BF_MAN_W) - {1'b0, lead_pos};
    assign sub_frac = man_in << shamt;

    // Choose the exponent and fraction by input class
    always_comb begin
        if (exp_in == '1) begin
            exp_out  = '1;
            frac_out = man_in;
        end else if (exp_in == '0 && man_in == '0) begin
            exp_out  = '0;
            frac_out = '0;
        end else if (exp_in == '0) begin
            exp_out  = SUB_BASE + DP_EXP_W'(lead_pos);
            frac_out = sub_frac;
        end else begin
            exp_out  = DP_EXP_W'(exp_in) + NORM_OFS;
            frac_out = man_in;
        end
    end

    assign dp_o = {sgn, exp_out, frac_out, {(DP_MAN_W-BF_MAN_W){1'b0}}};
endmodule

// File: rtl/bfl_seq.sv
// Write sequencer. An accepted start makes one write in scalar mode,
// or a run of writes to consecutive indices in vector mode. The caller
// must gate start_i with busy_o. The index wraps modulo NREG, which
// must be a power of two.
module bfl_seq import bfl_pkg::*; #(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG),
    localparam int VLW = $clog2(NREG) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            vec_i,
    input  logic [VLW-1:0]  vlen_i,
    input  logic [IW-1:0]   idx_i,
    input  logic [DP_W-1:0] data_i,
    output logic            wr_en_o,
    output logic [IW-1:0]   wr_idx_o,
    output logic [DP_W-1:0] wr_data_o,
    output logic            busy_o
);
    logic [VLW-1:0]  rem_q;
    logic [VLW-1:0]  vl_eff;
    logic            en_q;
    logic [IW-1:0]   idx_q;
    logic [DP_W-1:0] data_q;

    // Clamp the requested length to the register count
    assign vl_eff = (int'(vlen_i) > NREG) ? VLW'(NREG) : vlen_i;

    // Launch a write or step through a vector run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rem_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (start_i) begin
            if (vec_i && vl_eff == '0) begin
                en_q  <= 1'b0;
                rem_q <= '0;
            end else begin
                en_q   <= 1'b1;
                idx_q  <= idx_i;
                data_q <= data_i;
                rem_q  <= vec_i ? vl_eff - 1'b1 : '0;
            end
        end else if (rem_q != '0) begin
            en_q  <= 1'b1;
            idx_q <= idx_q + 1'b1;
            rem_q <= rem_q - 1'b1;
        end else begin
            en_q <= 1'b0;
        end
    end

    assign wr_en_o   = en_q;
    assign wr_idx_o  = idx_q;
    assign wr_data_o = data_q;
    assign busy_o    = (rem_q != '0);
endmodule

// File: rtl/bfl_loader.sv
// Top level of the float immediate loader: decode, widen, then sequence
// the writes. Issues are accepted only when the opcodes match and no
// vector run is in progress.
module bfl_loader import bfl_pkg::*; #(
    parameter int               NREG     = 32,
    parameter logic [OPC_W-1:0] MAJOR_OP = 6'd19,
    parameter logic [XO_W-1:0]  EXT_OP   = 6'd2,
    localparam int IW  = $clog2(NREG),
    localparam int VLW = $clog2(NREG) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [31:0]     insn_i,
    input  logic            vec_mode_i,
    input  logic [VLW-1:0]  vlen_i,
    output logic            wr_en_o,
    output logic [IW-1:0]   wr_idx_o,
    output logic [DP_W-1:0] wr_data_o,
    output logic            busy_o
);
    logic             match;
    logic [REG_W-1:0] frt;
    logic [BF_W-1:0]  bf;
    logic [DP_W-1:0]  dp;
    logic             start;

    bfl_decode #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) u_dec (
        .insn_i(insn_i), .match_o(match), .frt_o(frt), .bf_o(bf)
    );

    bfl_widen u_wid (.bf_i(bf), .dp_o(dp));

    // Accept an issue only when idle and the opcodes match
    assign start = issue_i && match && !busy_o;

    bfl_seq #(.NREG(NREG)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vec_i(vec_mode_i),
        .vlen_i(vlen_i), .idx_i(frt[IW-1:0]), .data_i(dp),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o)
    );
endmodule

// File: rtl/bfl_loader_chk.sv
// Temporal checks on the loader's write port, attached by bind.
module bfl_loader_chk #(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_i,
    input logic          wr_en_o,
    input logic [IW-1:0] wr_idx_o,
    input logic [63:0]   wr_data_o,
    input logic          busy_o
);
    AST_WRITE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !$past(wr_en_o)) |-> $past(issue_i)); // R3
    AST_VEC_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (wr_en_o && wr_idx_o == IW'($past(wr_idx_o) + 1'b1))); // R9
    AST_VEC_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(wr_data_o)); // R9
    AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_data_o[62:52] == 11'd0) |-> (wr_data_o[51:0] == 52'd0)); // R7
    AST_BUSY_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> wr_en_o); // R10
endmodule

bind bfl_loader bfl_loader_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .busy_o(busy_o)
);

// File: tb/tb_bfl_loader.sv
module tb_bfl_loader;
    localparam logic [5:0] MAJ = 6'd19;
    localparam logic [5:0] XO  = 6'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] insn = '0;
    logic        vec = 1'b0;
    logic [5:0]  vlen = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        busy;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    bfl_loader dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .insn_i(insn),
        .vec_mode_i(vec), .vlen_i(vlen), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .busy_o(busy)
    );

    always #5 clk = ~clk;

    // Reference widening done in real arithmetic; specials done from the R6 rule
    function automatic logic [63:0] ref_dp(input logic [15:0] b);
        logic [63:0] mag;
        real         r;
        int          e = int'(b[14:7]);
        int          f = int'(b[6:0]);
        if (e == 255) begin
            mag = {1'b0, 11'h7FF, b[6:0], 45'd0};
        end else begin
            if (e == 0) r = real'(f) * (2.0 ** (-133.0));
            else        r = (1.0 + real'(f) / 128.0) * (2.0 ** real'(e - 127));
            mag = $realtobits(r);
        end
        return {b[15], mag[62:0]};
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rd,
                                       input logic [15:0] b, input logic [5:0] xo);
        return {maj, rd, b[15:2], xo, b[0]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pulse issue for one cycle; returns at the negedge after the capturing edge
    task automatic do_issue(input logic [31:0] w, input logic v, input logic [5:0] vl);
        @(negedge clk);
        insn = w; vec = v; vlen = vl; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!wr_en && !busy, "R3 reset", {62'd0, wr_en, busy}, 64'd0);

        // R8 named examples
        do_issue(mk(MAJ, 5'd4, 16'h7F80, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'h7FF0000000000000, "R8 +inf", wr_data, 64'h7FF0000000000000);
        do_issue(mk(MAJ, 5'd4, 16'hFF80, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'hFFF0000000000000, "R8 -inf", wr_data, 64'hFFF0000000000000);
        do_issue(mk(MAJ, 5'd4, 16'h3FFF, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'h3FFFE00000000000, "R8 1.9921875", wr_data, 64'h3FFFE00000000000);
        do_issue(mk(MAJ, 5'd9, 16'h7FC3, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'h7FF8600000000000, "R6 nan payload", wr_data, 64'h7FF8600000000000);
        do_issue(mk(MAJ, 5'd9, 16'h0003, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'h37B8000000000000, "R7 subnormal", wr_data, 64'h37B8000000000000);
        do_issue(mk(MAJ, 5'd9, 16'h8000, XO), 1'b0, 6'd0);
        check(wr_en && wr_data == 64'h8000000000000000, "R5 -0", wr_data, 64'h8000000000000000);

        // R2 opcode mismatch: no write
        do_issue(mk(6'd20, 5'd1, 16'h3F80, XO), 1'b0, 6'd0);
        check(!wr_en, "R2 major", {63'd0, wr_en}, 64'd0);
        do_issue(mk(MAJ, 5'd1, 16'h3F80, 6'd3), 1'b0, 6'd0);
        check(!wr_en, "R2 ext", {63'd0, wr_en}, 64'd0);
        do_issue(mk(MAJ, 5'd1, 16'h3F80, 6'd3), 1'b1, 6'd8);
        check(!wr_en && !busy, "R2 vector", {62'd0, wr_en, busy}, 64'd0);

        // R1 R3..R7 full scalar sweep over every encodable immediate
        for (int v = 0; v < 32768; v++) begin
            logic [15:0] b;
            logic [4:0]  rd;
            logic [63:0] exp;
            string       tag;
            b  = {v[14:1], v[0], v[0]};
            rd = v[4:0] ^ v[9:5];
            exp = ref_dp(b);
            if (b[14:7] == 8'hFF)                         tag = "R1 R6";
            else if (b[14:7] == 8'd0 && b[6:0] == 7'd0)   tag = "R1 R5";
            else if (b[14:7] == 8'd0)                     tag = "R1 R7";
            else                                          tag = "R1 R4";
            do_issue(mk(MAJ, rd, b, XO), 1'b0, 6'd0);
            check(wr_en && wr_idx == rd && wr_data == exp, tag, wr_data, exp);
            @(negedge clk);
            check(!wr_en, "R3 single write", {63'd0, wr_en}, 64'd0);
        end

        // R9 R10: clear all 32 registers with one issue
        do_issue(mk(MAJ, 5'd0, 16'h0000, XO), 1'b1, 6'd32);
        for (int k = 0; k < 32; k++) begin
            check(wr_en && wr_idx == 5'(k) && wr_data == 64'd0, "R9 clear", {59'd0, wr_idx}, 64'(k));
            check(busy == (k < 31), "R10 busy", {63'd0, busy}, {63'd0, k < 31});
            @(negedge clk);
        end
        check(!wr_en && !busy, "R9 run end", {62'd0, wr_en, busy}, 64'd0);

        // R9 wrap, R10 issue during busy is dropped
        do_issue(mk(MAJ, 5'd30, 16'h3F80, XO), 1'b1, 6'd5);
        for (int k = 0; k < 5; k++) begin
            check(wr_en && wr_idx == 5'(30 + k) && wr_data == 64'h3FF0000000000000,
                  "R9 wrap", {59'd0, wr_idx}, 64'(5'(30 + k)));
            if (k == 1) begin
                insn = mk(MAJ, 5'd7, 16'h4000, XO); vec = 1'b0; issue = 1'b1;
            end else begin
                issue = 1'b0;
            end
            @(negedge clk);
        end
        check(!wr_en, "R10 ignored issue", {63'd0, wr_en}, 64'd0);

        // R11 zero length
        do_issue(mk(MAJ, 5'd3, 16'h3F80, XO), 1'b1, 6'd0);
        check(!wr_en && !busy, "R11 zero len", {62'd0, wr_en, busy}, 64'd0);
        @(negedge clk);
        check(!wr_en, "R11 zero len later", {63'd0, wr_en}, 64'd0);

        // R11 oversized length clamps to 32
        do_issue(mk(MAJ, 5'd5, 16'h4000, XO), 1'b1, 6'd40);
        begin
            int cnt = 0;
            for (int k = 0; k < 40; k++) begin
                if (wr_en) cnt++;
                @(negedge clk);
            end
            check(cnt == 32, "R11 clamp", 64'(cnt), 64'd32);
        end

        // R9 R10 length one behaves like a single write
        do_issue(mk(MAJ, 5'd12, 16'hBF80, XO), 1'b1, 6'd1);
        check(wr_en && !busy && wr_idx == 5'd12 && wr_data == 64'hBFF0000000000000,
              "R9 len one", wr_data, 64'hBFF0000000000000);
        @(negedge clk);
        check(!wr_en, "R10 len one end", {63'd0, wr_en}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule